// File: doc/BRIEF.md
# Parallel Display Bus Engine

This block turns single host transfers into timed cycles on an 8080-style parallel bus toward a display controller. The host presents a request with `host_valid`. `host_op` picks a command write, a data write or a read. Each accepted request becomes exactly one bus cycle. The cycle has a setup phase, a strobe phase and a hold phase, and a write cycle is optionally followed by an idle gap. Each phase length comes from its own cycle-count field in the timing and bus configuration words. The configuration and the write data are captured when the request is accepted.

The sequencer has five states:
- `ST_IDLE`: no transfer.
- `ST_SETUP`: chip select low, strobe high.
- `ST_STROBE`: write or read strobe low.
- `ST_HOLD`: strobe high again, chip select still low.
- `ST_GAP`: chip select high while the write-to-write gap runs.

The transitions are:
- start: `ST_IDLE` to the first non-empty phase, on accept.
- advance: to the next non-empty phase when the phase counter reaches zero.
- finish: to `ST_IDLE` after the last phase.
- chain: directly into a new cycle when a request is accepted in the last cycle of the current one.

Phases with a zero count are skipped, except the strobe, which always lasts at least one cycle. `host_ready` is high in `ST_IDLE` and in the final cycle of a transfer. A request that arrives early is therefore held off, never dropped.

Top module: `lcdb_engine`

## Requirements
- R1: `host_op` encoding: bit 1 = 1 selects a read, bit 0 is the command/data state. The `lcd_dc` line is low for a command cycle (op 2'b00) and high for a data cycle (2'b01, 2'b11). It stays constant for the whole setup, strobe and hold window of the cycle.
- R2: Write timing word fields:
  - bits 5:0: strobe count W
  - bits 11:8: setup count S
  - bits 15:12: hold count H

  After the accepting edge, a write cycle runs for S+W+1+H cycles. `lcd_cs_n` is low throughout. `lcd_wr_n` is low exactly in cycles S+1 to S+W+1. `lcd_rd_n` stays high.
- R3: Read timing word fields:
  - bits 21:16: latency L, up to 63
  - bits 27:24: setup Sr
  - bits 31:28: hold Hr

  `lcd_rd_n` is low in cycles Sr+1 to Sr+L+1, and `lcd_cs_n` is low for Sr+L+1+Hr cycles. `lcd_din` is sampled at the edge that ends the strobe. `rd_valid` is high for one cycle right after that edge, with the sample on `rd_data`, which then holds its value.
- R4: Bus width code in `bus_cfg[1:0]`: 0 = 8 bits, 1 = 9 bits, 2 or 3 = 16 bits. Write data on `lcd_dout` and read data on `rd_data` carry only the low width bits, and the upper lines are zero. `lcd_dout` is zero whenever `lcd_doe` is low. `lcd_doe` is high exactly during the setup, strobe and hold window of a write.
- R5: Write-to-write gap G is in `bus_cfg[19:16]`. After a write's hold phase, `lcd_cs_n` is high and `host_ready` low for G cycles. With G = 0 a new write may start in the very next cycle with no idle cycle between strobes.
- R6: `host_ready` is low while a transfer is in flight, except in its last cycle, and high when idle. A request held with `host_valid` high during a transfer is accepted later and carried out with its data intact.
- R7: `busy` is high from the cycle after acceptance until the transfer, including any gap, is over, and low otherwise.
- R8: `lcd_rst_n` follows a control bit written with `prst_we`/`prst_val`. The bit resets to 0 (panel reset asserted). A write of 1 releases it and a write of 0 asserts it, with effect in the next cycle.
- R9: Configuration words and write data changed after the accepting edge have no effect on the transfer in progress.
- R10: After reset the bus is idle: `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are high, `lcd_doe` is low, `host_ready` is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host request present |
| host_op | input | 2 | Bit 1 read, bit 0 command(0)/data(1) |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | Request accepted on this edge when valid |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 16 | Read result, width-masked |
| timing_cfg | input | 32 | Phase counts for write and read cycles |
| bus_cfg | input | 32 | Width code and write-to-write gap |
| prst_we | input | 1 | Panel reset control write enable |
| prst_val | input | 1 | Panel reset control value (0 asserts) |
| busy | output | 1 | Transfer in progress |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_dc | output | 1 | Command (0) / data (1) line |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_dout | output | 16 | Bus write data |
| lcd_doe | output | 1 | Bus data output enable |
| lcd_din | input | 16 | Bus read data |

## Verification
Cycle 1 is the first cycle after the accepting edge. Bus pins reflect the sequencer state combinationally, so a write's strobe is due in cycles S+1 to S+W+1 and its chip select in cycles 1 to S+W+1+H. `host_ready` is due in the last of the S+W+1+H+G cycles. A read's `rd_valid` lands in cycle Sr+L+2, one register after the sampling edge, and `lcd_rst_n` moves one cycle after a control write. The bench drives on the falling edge, walks a cycle index from the acceptance, and compares each pin at every falling edge against the value computed from that index. It also scrambles the configuration right after acceptance, so any late use of a live field shows up as a phase mismatch.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

    localparam int CNT_W      = 6;
    localparam int PH_W       = 4;

    // timing_cfg field positions
    localparam int WR_STB_LSB = 0;
    localparam int WR_STB_W   = 6;
    localparam int WR_SU_LSB  = 8;
    localparam int WR_HD_LSB  = 12;
    localparam int RD_LAT_LSB = 16;
    localparam int RD_LAT_W   = 6;
    localparam int RD_SU_LSB  = 24;
    localparam int RD_HD_LSB  = 28;

    // bus_cfg field positions
    localparam int BW_LSB     = 0;
    localparam int BW_W       = 2;
    localparam int GAP_LSB    = 16;

    localparam logic [1:0] WCODE_8 = 2'd0;
    localparam logic [1:0] WCODE_9 = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_GAP    = 3'd4
    } bus_state_e;

    typedef struct packed {
        logic [PH_W-1:0]  setup;
        logic [CNT_W-1:0] strobe;
        logic [PH_W-1:0]  hold;
        logic [PH_W-1:0]  gap;
        logic             is_read;
    } phase_cfg_t;

    typedef struct packed {
        bus_state_e       st;
        logic [CNT_W-1:0] cnt;
    } step_t;

    // First non-empty phase at or after position 'from' (1=setup .. 4=gap).
    function automatic step_t first_step(phase_cfg_t c, logic [2:0] from);
        step_t s;
        if (from <= 3'd1 && c.setup != '0) begin
            s.st  = ST_SETUP;
            s.cnt = CNT_W'(c.setup) - CNT_W'(1);
        end else if (from <= 3'd2) begin
            s.st  = ST_STROBE;
            s.cnt = c.strobe;
        end else if (from <= 3'd3 && c.hold != '0) begin
            s.st  = ST_HOLD;
            s.cnt = CNT_W'(c.hold) - CNT_W'(1);
        end else if (from <= 3'd4 && !c.is_read && c.gap != '0) begin
            s.st  = ST_GAP;
            s.cnt = CNT_W'(c.gap) - CNT_W'(1);
        end else begin
            s.st  = ST_IDLE;
            s.cnt = '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/lcdb_cfg_decode.sv
module lcdb_cfg_decode
    import lcdb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [31:0]       timing_cfg,
    input  logic [31:0]       bus_cfg,
    input  logic              op_read,
    output phase_cfg_t        ph,
    output logic [DATA_W-1:0] mask
);

    logic [BW_W-1:0] wcode;
    int              nbits;
    logic            unused_bits;

    assign wcode       = bus_cfg[BW_LSB +: BW_W];
    assign unused_bits = ^{timing_cfg[7:6], timing_cfg[23:22],
                           bus_cfg[15:2], bus_cfg[31:20]};

    always_comb begin
        ph         = '0;
        ph.is_read = op_read;
        if (op_read) begin
            ph.setup  = timing_cfg[RD_SU_LSB +: PH_W];
            ph.strobe = CNT_W'(timing_cfg[RD_LAT_LSB +: RD_LAT_W]);
            ph.hold   = timing_cfg[RD_HD_LSB +: PH_W];
            ph.gap    = '0;
        end else begin
            ph.setup  = timing_cfg[WR_SU_LSB +: PH_W];
            ph.strobe = CNT_W'(timing_cfg[WR_STB_LSB +: WR_STB_W]);
            ph.hold   = timing_cfg[WR_HD_LSB +: PH_W];
            ph.gap    = bus_cfg[GAP_LSB +: PH_W];
        end
    end

    always_comb begin
        unique case (wcode)
            WCODE_8: nbits = 8;
            WCODE_9: nbits = 9;
            default: nbits = DATA_W;
        endcase
        if (nbits > DATA_W) nbits = DATA_W;
    end

    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_mask
            assign mask[g] = (g < nbits);
        end
    endgenerate

endmodule

// File: rtl/lcdb_seq.sv
module lcdb_seq
    import lcdb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  phase_cfg_t new_ph,
    output logic       host_ready,
    output logic       busy,
    output logic       bus_active,
    output logic       wr_strobe,
    output logic       rd_strobe,
    output logic       strobe_end,
    output logic       cur_is_read
);

    bus_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    phase_cfg_t       cur_ph;
    logic [2:0]       st_bits;
    step_t            after, fresh;
    logic             last_cycle;

    assign st_bits     = state;
    assign after       = first_step(cur_ph, st_bits + 3'd1);
    assign fresh       = first_step(new_ph, 3'd1);
    assign last_cycle  = (state != ST_IDLE) && (cnt == '0) && (after.st == ST_IDLE);
    assign cur_is_read = cur_ph.is_read;

    // next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nxt = fresh.st;
                    cnt_nxt   = fresh.cnt;
                end
            end
            ST_SETUP, ST_STROBE, ST_HOLD, ST_GAP: begin
                if (cnt != '0) begin
                    cnt_nxt = cnt - CNT_W'(1);
                end else if (last_cycle && accept) begin
                    state_nxt = fresh.st;
                    cnt_nxt   = fresh.cnt;
                end else begin
                    state_nxt = after.st;
                    cnt_nxt   = after.cnt;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            cur_ph <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (accept) cur_ph <= new_ph;
        end
    end

    // outputs
    always_comb begin
        bus_active = 1'b0;
        wr_strobe  = 1'b0;
        rd_strobe  = 1'b0;
        strobe_end = 1'b0;
        busy       = 1'b1;
        host_ready = last_cycle;
        unique case (state)
            ST_IDLE: begin
                busy       = 1'b0;
                host_ready = 1'b1;
            end
            ST_SETUP: begin
                bus_active = 1'b1;
            end
            ST_STROBE: begin
                bus_active = 1'b1;
                wr_strobe  = !cur_ph.is_read;
                rd_strobe  = cur_ph.is_read;
                strobe_end = (cnt == '0);
            end
            ST_HOLD: begin
                bus_active = 1'b1;
            end
            ST_GAP: begin
                bus_active = 1'b0;
            end
            default: begin
                busy       = 1'b0;
                host_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lcdb_datapath.sv
module lcdb_datapath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              op_dc,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mask_in,
    input  logic              bus_active,
    input  logic              strobe_end,
    input  logic              cur_is_read,
    input  logic [DATA_W-1:0] lcd_din,
    output logic [DATA_W-1:0] lcd_dout,
    output logic              lcd_doe,
    output logic              lcd_dc,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] mask_q;
    logic              dc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q  <= '0;
            mask_q   <= '0;
            dc_q     <= 1'b1;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                wdata_q <= host_wdata & mask_in;
                mask_q  <= mask_in;
                dc_q    <= op_dc;
            end
            rd_valid <= strobe_end && cur_is_read;
            if (strobe_end && cur_is_read) rd_data <= lcd_din & mask_q;
        end
    end

    assign lcd_doe  = bus_active && !cur_is_read;
    assign lcd_dout = lcd_doe ? wdata_q : '0;
    assign lcd_dc   = dc_q;

endmodule

// File: rtl/lcdb_engine.sv
module lcdb_engine
    import lcdb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [1:0]        host_op,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [31:0]       timing_cfg,
    input  logic [31:0]       bus_cfg,
    input  logic              prst_we,
    input  logic              prst_val,
    output logic              busy,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic              lcd_rd_n,
    output logic              lcd_dc,
    output logic              lcd_rst_n,
    output logic [DATA_W-1:0] lcd_dout,
    output logic              lcd_doe,
    input  logic [DATA_W-1:0] lcd_din
);

    phase_cfg_t        new_ph;
    logic [DATA_W-1:0] mask;
    logic              accept;
    logic              bus_active, wr_strobe, rd_strobe, strobe_end, cur_is_read;
    logic              prst_q;

    assign accept = host_valid && host_ready;

    lcdb_cfg_decode #(.DATA_W(DATA_W)) dec_i (
        .timing_cfg (timing_cfg),
        .bus_cfg    (bus_cfg),
        .op_read    (host_op[1]),
        .ph         (new_ph),
        .mask       (mask)
    );

    lcdb_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .new_ph      (new_ph),
        .host_ready  (host_ready),
        .busy        (busy),
        .bus_active  (bus_active),
        .wr_strobe   (wr_strobe),
        .rd_strobe   (rd_strobe),
        .strobe_end  (strobe_end),
        .cur_is_read (cur_is_read)
    );

    lcdb_datapath #(.DATA_W(DATA_W)) dp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .op_dc       (host_op[0]),
        .host_wdata  (host_wdata),
        .mask_in     (mask),
        .bus_active  (bus_active),
        .strobe_end  (strobe_end),
        .cur_is_read (cur_is_read),
        .lcd_din     (lcd_din),
        .lcd_dout    (lcd_dout),
        .lcd_doe     (lcd_doe),
        .lcd_dc      (lcd_dc),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prst_q <= 1'b0;
        else if (prst_we) prst_q <= prst_val;
    end

    assign lcd_rst_n = prst_q;
    assign lcd_cs_n  = !bus_active;
    assign lcd_wr_n  = !wr_strobe;
    assign lcd_rd_n  = !rd_strobe;

endmodule

// File: rtl/lcdb_engine_chk.sv
module lcdb_engine_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_ready,
    input logic              busy,
    input logic              lcd_cs_n,
    input logic              lcd_wr_n,
    input logic              lcd_rd_n,
    input logic              lcd_dc,
    input logic              lcd_doe,
    input logic [DATA_W-1:0] lcd_dout,
    input logic              lcd_rst_n,
    input logic              rd_valid,
    input logic              prst_we,
    input logic              prst_val
);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lcd_wr_n && !lcd_rd_n));

    a_r2_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_wr_n || !lcd_rd_n) |-> !lcd_cs_n);

    a_r1_dc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && $past(!lcd_cs_n) && !$past(host_valid && host_ready)) |-> $stable(lcd_dc));

    a_r4_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && $past(!lcd_cs_n) && !$past(host_valid && host_ready)) |-> $stable(lcd_dout));

    a_r4_dout_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_doe |-> (lcd_dout == '0));

    a_r7_busy_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_cs_n |-> busy);

    a_r6_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> host_ready);

    a_r3_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!lcd_rd_n));

    a_r8_release_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_rst_n) |-> $past(prst_we && prst_val));

endmodule

bind lcdb_engine lcdb_engine_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .busy       (busy),
    .lcd_cs_n   (lcd_cs_n),
    .lcd_wr_n   (lcd_wr_n),
    .lcd_rd_n   (lcd_rd_n),
    .lcd_dc     (lcd_dc),
    .lcd_doe    (lcd_doe),
    .lcd_dout   (lcd_dout),
    .lcd_rst_n  (lcd_rst_n),
    .rd_valid   (rd_valid),
    .prst_we    (prst_we),
    .prst_val   (prst_val)
);

// File: tb/lcdb_engine_tb_top.sv
`timescale 1ns/1ps
module lcdb_engine_tb_top;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_valid = 1'b0;
    logic [1:0]    host_op = 2'b00;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready, rd_valid, busy;
    logic [DW-1:0] rd_data, lcd_dout;
    logic [31:0]   timing_cfg = '0, bus_cfg = '0;
    logic          prst_we = 1'b0, prst_val = 1'b0;
    logic          lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_dc, lcd_rst_n, lcd_doe;
    logic [DW-1:0] lcd_din = '0;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    lcdb_engine #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_op(host_op),
        .host_wdata(host_wdata), .host_ready(host_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .timing_cfg(timing_cfg), .bus_cfg(bus_cfg),
        .prst_we(prst_we), .prst_val(prst_val), .busy(busy),
        .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
        .lcd_dc(lcd_dc), .lcd_rst_n(lcd_rst_n), .lcd_dout(lcd_dout),
        .lcd_doe(lcd_doe), .lcd_din(lcd_din)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mask_of(input int wc);
        if (wc == 0) return 16'h00FF;
        if (wc == 1) return 16'h01FF;
        return 16'hFFFF;
    endfunction

    task automatic do_write(input bit isdata, input logic [DW-1:0] d,
                            input int s, input int w, input int h, input int g, input int wc);
        int t, tot;
        bit ok_ph, ok_dc, ok_d, ok_rdy, ok_busy;
        logic [31:0] a_ph, e_ph, a_d, e_d, a_r, e_r;
        logic        e_cs, e_wr;
        logic [DW-1:0] e_out;
        ok_ph = 1; ok_dc = 1; ok_d = 1; ok_rdy = 1; ok_busy = 1;
        a_ph = 0; e_ph = 0; a_d = 0; e_d = 0; a_r = 0; e_r = 0;
        t   = s + w + 1 + h;
        tot = t + g;
        @(negedge clk);
        timing_cfg = 32'(w) | (32'(s) << 8) | (32'(h) << 12);
        bus_cfg    = 32'(wc) | (32'(g) << 16);
        host_op    = {1'b0, isdata};
        host_wdata = d;
        host_valid = 1'b1;
        chk(host_ready === 1'b1, "R6", "ready before write", 32'(host_ready), 1);
        @(negedge clk);
        host_valid = 1'b0;
        timing_cfg = 32'hFFFF_FFFF;   // R9: scramble after acceptance
        bus_cfg    = 32'h000F_0000;
        host_wdata = '1;
        for (int k = 1; k <= tot + 1; k++) begin
            if (k > 1) @(negedge clk);
            e_cs  = !(k <= t);
            e_wr  = !(k > s && k <= s + w + 1);
            e_out = (k <= t) ? (d & mask_of(wc)) : '0;
            if (ok_ph && (lcd_cs_n !== e_cs || lcd_wr_n !== e_wr || lcd_rd_n !== 1'b1)) begin
                ok_ph = 0; a_ph = {k[15:0], 13'd0, lcd_cs_n, lcd_wr_n, lcd_rd_n};
                e_ph = {k[15:0], 13'd0, e_cs, e_wr, 1'b1};
            end
            if (k <= t && lcd_dc !== isdata) ok_dc = 0;
            if (ok_d && (lcd_dout !== e_out || lcd_doe !== (k <= t))) begin
                ok_d = 0; a_d = {15'd0, lcd_doe, lcd_dout}; e_d = {15'd0, (k <= t), e_out};
            end
            if (ok_rdy && host_ready !== (k >= tot)) begin
                ok_rdy = 0; a_r = {k[15:0], 15'd0, host_ready}; e_r = {k[15:0], 15'd0, (k >= tot)};
            end
            if (busy !== (k <= tot)) ok_busy = 0;
        end
        chk(ok_ph,   "R2/R9", "write phases (cycle,cs,wr,rd)", a_ph, e_ph);
        chk(ok_dc,   "R1", "dc during write", 32'(lcd_dc), 32'(isdata));
        chk(ok_d,    "R4", "write data masking (doe,dout)", a_d, e_d);
        chk(ok_rdy,  "R5 R6", "ready/gap timing (cycle,ready)", a_r, e_r);
        chk(ok_busy, "R7", "busy window", 0, 1);
    endtask

    task automatic do_read(input int s, input int l, input int h, input int wc,
                           input logic [DW-1:0] din);
        int t, due;
        bit ok_ph, ok_v, ok_d, ok_dc;
        logic [31:0] a_ph, e_ph;
        logic e_cs, e_rd;
        ok_ph = 1; ok_v = 1; ok_d = 1; ok_dc = 1; a_ph = 0; e_ph = 0;
        t   = s + l + 1 + h;
        due = s + l + 2;
        @(negedge clk);
        timing_cfg = (32'(l) << 16) | (32'(s) << 24) | (32'(h) << 28);
        bus_cfg    = 32'(wc);
        host_op    = 2'b11;
        lcd_din    = din;
        host_valid = 1'b1;
        @(negedge clk);
        host_valid = 1'b0;
        timing_cfg = 32'h00FF_FF00;   // R9: scramble after acceptance
        bus_cfg    = 32'h0000_0000;
        for (int k = 1; k <= t + 2; k++) begin
            if (k > 1) @(negedge clk);
            e_cs = !(k <= t);
            e_rd = !(k > s && k <= s + l + 1);
            if (ok_ph && (lcd_cs_n !== e_cs || lcd_rd_n !== e_rd || lcd_wr_n !== 1'b1 || lcd_doe !== 1'b0)) begin
                ok_ph = 0; a_ph = {k[15:0], 12'd0, lcd_cs_n, lcd_rd_n, lcd_wr_n, lcd_doe};
                e_ph = {k[15:0], 12'd0, e_cs, e_rd, 1'b1, 1'b0};
            end
            if (k <= t && lcd_dc !== 1'b1) ok_dc = 0;
            if (rd_valid !== (k == due)) ok_v = 0;
            if (k == due) begin
                if (rd_data !== (din & mask_of(wc))) ok_d = 0;
                lcd_din = ~din;
            end
            if (k > due && rd_data !== (din & mask_of(wc))) ok_d = 0;
        end
        chk(ok_ph, "R3/R9", "read phases (cycle,cs,rd,wr,doe)", a_ph, e_ph);
        chk(ok_v,  "R3", "rd_valid single pulse", 32'(rd_valid), 0);
        chk(ok_d,  "R4", "read data masked and held", 32'(rd_data), 32'(din & mask_of(wc)));
        chk(ok_dc, "R1", "dc high during data read", 32'(lcd_dc), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int idx;
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        // R10 / R8 reset state
        chk(lcd_cs_n === 1 && lcd_wr_n === 1 && lcd_rd_n === 1, "R10", "strobes idle in reset",
            {29'd0, lcd_cs_n, lcd_wr_n, lcd_rd_n}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready === 1 && busy === 0 && lcd_doe === 0, "R10", "ready/busy/doe after reset",
            {29'd0, host_ready, busy, lcd_doe}, 4);
        chk(lcd_rst_n === 0, "R8", "panel reset asserted at reset", 32'(lcd_rst_n), 0);
        prst_we = 1; prst_val = 1;
        @(negedge clk);
        prst_we = 0; prst_val = 0;
        chk(lcd_rst_n === 1, "R8", "release after writing 1", 32'(lcd_rst_n), 1);
        @(negedge clk);
        chk(lcd_rst_n === 1, "R8", "holds without write", 32'(lcd_rst_n), 1);
        prst_we = 1; prst_val = 0;
        @(negedge clk);
        prst_we = 0;
        chk(lcd_rst_n === 0, "R8", "assert after writing 0", 32'(lcd_rst_n), 0);

        // write sweep
        idx = 0;
        for (int s = 0; s <= 2; s += 2)
            for (int w = 0; w <= 3; w += 3)
                for (int h = 0; h <= 1; h++)
                    for (int g = 0; g <= 2; g += 2)
                        for (int wc = 0; wc <= 2; wc++)
                            for (int op = 0; op <= 1; op++) begin
                                idx++;
                                d = 16'hFFFF ^ (16'(idx) * 16'h1357);
                                do_write(op[0], d, s, w, h, g, wc);
                            end

        // read sweep
        for (int s = 0; s <= 1; s++)
            for (int l = 0; l <= 4; l += 4)
                for (int h = 0; h <= 2; h += 2)
                    for (int wc = 0; wc <= 2; wc++)
                        do_read(s, l, h, wc, 16'hA5C3);

        // R5: back-to-back writes with zero gap, three strobes in three cycles
        begin
            bit ok_b;
            logic [DW-1:0] dv [3];
            dv[0] = 16'h1111; dv[1] = 16'h2222; dv[2] = 16'h3333;
            ok_b = 1;
            @(negedge clk);
            timing_cfg = 32'h0; bus_cfg = 32'd2;
            host_op = 2'b01; host_wdata = dv[0]; host_valid = 1;
            for (int k = 1; k <= 4; k++) begin
                @(negedge clk);
                if (k <= 2) host_wdata = dv[k];
                else host_valid = 0;
                if (k <= 3 && (lcd_wr_n !== 0 || lcd_cs_n !== 0 || lcd_dout !== dv[k-1])) ok_b = 0;
                if (k == 4 && lcd_cs_n !== 1) ok_b = 0;
            end
            chk(ok_b, "R5", "zero-gap back-to-back writes", 32'(lcd_dout), 32'(dv[2]));
        end

        // R6: request held during a transfer is accepted afterwards, data intact
        begin
            bit ok_h;
            int nlow;
            ok_h = 1; nlow = 0;
            @(negedge clk);
            timing_cfg = 32'h0000_1101;   // W=1 S=1 H=1
            bus_cfg    = 32'h0002_0002;   // G=2, 16-bit
            host_op = 2'b01; host_wdata = 16'hBEEF; host_valid = 1;
            @(negedge clk);
            host_wdata = 16'hCAFE;
            for (int k = 1; k <= 14; k++) begin
                if (k > 1) @(negedge clk);
                if (lcd_wr_n !== !(k == 2 || k == 3 || k == 8 || k == 9)) ok_h = 0;
                if (lcd_wr_n === 0) nlow++;
                if ((k == 2 || k == 3) && lcd_dout !== 16'hBEEF) ok_h = 0;
                if ((k == 8 || k == 9) && lcd_dout !== 16'hCAFE) ok_h = 0;
                if ((k == 5 || k == 6) && lcd_cs_n !== 1) ok_h = 0;
                if (k >= 1 && k <= 5 && host_ready !== 0) ok_h = 0;
                if (k == 7) host_valid = 0;
            end
            chk(ok_h, "R6", "held request executed later", 32'(nlow), 4);
        end

        @(negedge clk);
        chk(busy === 0 && host_ready === 1, "R7", "idle after all traffic",
            {30'd0, busy, host_ready}, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule